// File: doc/BRIEF.md
# Serial Port with Queued Receive and Software-Cleared Flags

This block is a full-duplex asynchronous serial port that carries 8-bit frames with no parity: a low start bit, eight data bits least significant first, and a high stop bit. The line idles high. Both directions are timed from an external tick that runs at sixteen times the bit rate. Software reaches the port through one data location. A write places a byte in a transmit holding register, and the transmitter sends that byte as soon as the line is free. A read takes the oldest byte out of a receive queue that holds three bytes. The transmitted byte can never be read back.

The receiver resynchronises the serial input and confirms a start bit halfway through the bit. It then samples each data bit at its centre. If a byte arrives while the queue is full, the byte is lost and a sticky overrun bit is set. Two flags tell software what happened: one for a finished transmission and one for data waiting. The hardware never clears either flag. Software must clear each one, and the hardware refuses to clear the receive flag while bytes are still queued. One interrupt request combines the two flags under an enable.

Top module: `serial_port_core`

## Requirements
- R1: After reset, `txd` is 1, `tx_done`, `rx_avail`, `rx_ovf` and `irq` are 0, and `rdata` is 0x00.
- R2: A `wr_en` pulse loads `wdata` into the holding register. The byte then goes out on `txd` as a frame: start bit 0, eight data bits with bit 0 first, then stop bit 1. Each bit lasts 16 `baud_tick` pulses, and `txd` rests at 1 between frames.
- R3: `tx_done` becomes 1 when a stop bit has been fully sent. It stays 1 through reads, writes and further ticks until a `clr_tx_done` pulse clears it.
- R4: A frame on `rxd` with a valid high stop bit queues its byte and sets `rx_avail`. A `rd_en` pulse presents the oldest queued byte on `rdata` from the next cycle onward.
- R5: The receive queue holds three bytes and returns them in arrival order. A byte that completes while three bytes are queued and no read is under way is dropped, and this sets `rx_ovf`.
- R6: `rx_ovf` stays 1 until a `clr_ovf` pulse clears it. Reading the queue does not clear it.
- R7: A `clr_rx_avail` pulse has no effect if at least one byte will remain queued after that cycle's read. When the queue is empty, the pulse clears `rx_avail`.
- R8: A `rd_en` pulse with the queue empty leaves `rdata` and all flags unchanged.
- R9: `irq` equals `irq_en` AND (`tx_done` OR `rx_avail`).
- R10: A low level on `rxd` that ends before half a bit time has passed is not taken as a start bit, and no byte is queued.
- R11: A frame whose stop bit samples low is discarded. No byte is queued and `rx_avail` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| wr_en | input | 1 | Write the data location (load transmit holding register) |
| wdata | input | 8 | Byte to transmit |
| rd_en | input | 1 | Read the data location (pop receive queue) |
| rdata | output | 8 | Most recently popped receive byte |
| clr_tx_done | input | 1 | Software clear of the transmit-complete flag |
| clr_rx_avail | input | 1 | Software clear request for the receive flag |
| clr_ovf | input | 1 | Software clear of the overrun bit |
| irq_en | input | 1 | Interrupt enable |
| tx_done | output | 1 | Transmit-complete flag |
| rx_avail | output | 1 | Receive-available flag |
| rx_ovf | output | 1 | Sticky receive overrun |
| irq | output | 1 | Combined interrupt request |

## Verification
The queue's occupancy cannot be seen directly. A wrong count or a stray pointer shows up on `rdata` at the next read: bytes arrive reordered, duplicated or stale. It also shows up when `rx_avail` accepts or refuses a clear that it should not. A wrong receive sampling point corrupts the byte read back about one frame (640 clocks here) after the stimulus. A wrong transmit bit counter produces a misframed byte, which the bench's line monitor decodes within the same frame. Random byte streams with random read points are compared against a queue model kept in the bench, so an overrun or ordering fault surfaces at the first read that follows it.

// File: rtl/serial_port_pkg.sv
package serial_port_pkg;
    typedef enum logic [1:0] {
        LN_IDLE  = 2'd0,
        LN_START = 2'd1,
        LN_DATA  = 2'd2,
        LN_STOP  = 2'd3
    } line_state_e;
endpackage

// File: rtl/sp_tx.sv
module sp_tx
    import serial_port_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              txd,
    output logic              done
);
    localparam int TW = $clog2(OSR);
    localparam int BW = $clog2(DATA_W);

    typedef struct packed {
        line_state_e       state;
        logic [TW-1:0]     tickcnt;
        logic [BW-1:0]     bitcnt;
        logic [DATA_W-1:0] shift;
        logic [DATA_W-1:0] hold;
        logic              hold_v;
        logic              txd;
        logic              done;
    } tx_st_t;

    tx_st_t q, d;

    always_comb begin
        d = q;
        d.done = 1'b0;
        if (load) begin
            d.hold   = load_data;
            d.hold_v = 1'b1;
        end
        case (q.state)
            LN_IDLE: begin
                if (tick && q.hold_v) begin
                    d.state   = LN_START;
                    d.shift   = q.hold;
                    d.hold_v  = load;
                    d.txd     = 1'b0;
                    d.tickcnt = '0;
                end
            end
            default: begin
                if (tick) begin
                    if (q.tickcnt == TW'(OSR - 1)) begin
                        d.tickcnt = '0;
                        case (q.state)
                            LN_START: begin
                                d.state  = LN_DATA;
                                d.bitcnt = '0;
                                d.txd    = q.shift[0];
                            end
                            LN_DATA: begin
                                if (q.bitcnt == BW'(DATA_W - 1)) begin
                                    d.state = LN_STOP;
                                    d.txd   = 1'b1;
                                end else begin
                                    d.bitcnt = q.bitcnt + 1'b1;
                                    d.shift  = q.shift >> 1;
                                    d.txd    = q.shift[1];
                                end
                            end
                            default: begin
                                d.state = LN_IDLE;
                                d.done  = 1'b1;
                            end
                        endcase
                    end else begin
                        d.tickcnt = q.tickcnt + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= LN_IDLE;
            q.txd   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign txd  = q.txd;
    assign done = q.done;

    // R2: a completed frame leaves the line idle and high
    a_r2_done_line_idle: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (q.state == LN_IDLE) && q.txd);
endmodule

// File: rtl/sp_rx.sv
module sp_rx
    import serial_port_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    output logic              push,
    output logic [DATA_W-1:0] push_data
);
    localparam int TW = $clog2(OSR);
    localparam int BW = $clog2(DATA_W);

    typedef struct packed {
        logic [1:0]        sync;
        line_state_e       state;
        logic [TW-1:0]     tickcnt;
        logic [BW-1:0]     bitcnt;
        logic [DATA_W-1:0] shift;
        logic              push;
        logic [DATA_W-1:0] data;
    } rx_st_t;

    rx_st_t q, d;
    logic   line;

    assign line = q.sync[1];

    always_comb begin
        d = q;
        d.sync = {q.sync[0], rxd};
        d.push = 1'b0;
        case (q.state)
            LN_IDLE: begin
                if (tick && !line) begin
                    d.state   = LN_START;
                    d.tickcnt = '0;
                end
            end
            LN_START: begin
                if (tick) begin
                    if (q.tickcnt == TW'(OSR / 2 - 1)) begin
                        d.tickcnt = '0;
                        d.bitcnt  = '0;
                        d.state   = line ? LN_IDLE : LN_DATA;
                    end else begin
                        d.tickcnt = q.tickcnt + 1'b1;
                    end
                end
            end
            LN_DATA: begin
                if (tick) begin
                    if (q.tickcnt == TW'(OSR - 1)) begin
                        d.tickcnt = '0;
                        d.shift   = {line, q.shift[DATA_W-1:1]};
                        if (q.bitcnt == BW'(DATA_W - 1)) d.state = LN_STOP;
                        else d.bitcnt = q.bitcnt + 1'b1;
                    end else begin
                        d.tickcnt = q.tickcnt + 1'b1;
                    end
                end
            end
            default: begin
                if (tick) begin
                    if (q.tickcnt == TW'(OSR - 1)) begin
                        d.tickcnt = '0;
                        d.state   = LN_IDLE;
                        if (line) begin
                            d.push = 1'b1;
                            d.data = q.shift;
                        end
                    end else begin
                        d.tickcnt = q.tickcnt + 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.sync  <= 2'b11;
            q.state <= LN_IDLE;
        end else begin
            q <= d;
        end
    end

    assign push      = q.push;
    assign push_data = q.data;

    // R4: a byte is only delivered after the stop-bit state
    a_r4_push_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
        q.push |-> $past(q.state) == LN_STOP);
endmodule

// File: rtl/sp_rxq.sv
module sp_rxq #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic              drop
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PW-1:0]                rp;
        logic [PW-1:0]                wp;
        logic [CW-1:0]                cnt;
    } q_st_t;

    q_st_t q, d;
    logic  do_pop, do_push;

    function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        d       = q;
        do_pop  = pop && (q.cnt != '0);
        do_push = push && ((q.cnt != CW'(DEPTH)) || do_pop);
        drop    = push && !do_push;
        if (do_push) begin
            d.mem[q.wp] = push_data;
            d.wp        = wrap_inc(q.wp);
        end
        if (do_pop) d.rp = wrap_inc(q.rp);
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head  = q.mem[q.rp];
    assign count = q.cnt;

    // R5: occupancy never exceeds the queue depth
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));
endmodule

// File: rtl/serial_port_core.sv
module serial_port_core #(
    parameter int DATA_W = 8,
    parameter int OSR    = 16,
    parameter int DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              rxd,
    output logic              txd,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    input  logic              clr_tx_done,
    input  logic              clr_rx_avail,
    input  logic              clr_ovf,
    input  logic              irq_en,
    output logic              tx_done,
    output logic              rx_avail,
    output logic              rx_ovf,
    output logic              irq
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              txdone;
        logic              rxavail;
        logic              ovf;
    } top_st_t;

    top_st_t           q, d;
    logic              tx_fin, rx_push, q_drop, pop_ok, empty_after;
    logic [DATA_W-1:0] rx_byte, q_head;
    logic [CW-1:0]     q_cnt;

    sp_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .load(wr_en),
        .load_data(wdata), .txd(txd), .done(tx_fin)
    );

    sp_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd(rxd),
        .push(rx_push), .push_data(rx_byte)
    );

    sp_rxq #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_q (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .push_data(rx_byte),
        .pop(rd_en), .head(q_head), .count(q_cnt), .drop(q_drop)
    );

    always_comb begin
        d           = q;
        pop_ok      = rd_en && (q_cnt != '0);
        empty_after = (q_cnt == '0) || ((q_cnt == CW'(1)) && pop_ok);
        if (pop_ok) d.rdata = q_head;
        d.txdone  = (q.txdone && !clr_tx_done) || tx_fin;
        d.rxavail = (q.rxavail && !(clr_rx_avail && empty_after)) || rx_push;
        d.ovf     = (q.ovf && !clr_ovf) || q_drop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata    = q.rdata;
    assign tx_done  = q.txdone;
    assign rx_avail = q.rxavail;
    assign rx_ovf   = q.ovf;
    assign irq      = irq_en && (q.txdone || q.rxavail);

    // R5: a dropped byte is reported as overrun
    a_r5_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        q_drop |=> rx_ovf);
    // R6: overrun holds without a clear
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf && !clr_ovf |=> rx_ovf);
    // R3: transmit flag holds without a clear
    a_r3_txdone_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done && !clr_tx_done |=> tx_done);
    // R7: clear refused while two or more bytes are queued
    a_r7_rxavail_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_avail && clr_rx_avail && (q_cnt >= CW'(2)) |=> rx_avail);
    // R8: reading an empty queue leaves the data output alone
    a_r8_empty_read_stable: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (q_cnt == '0) |=> $stable(rdata));
    // R4: the receive flag rises only with data queued
    a_r4_rxavail_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_avail) |-> (q_cnt != '0));
endmodule

// File: tb/sim_serial_port_core.sv
module sim_serial_port_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       txd;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic       clr_tx_done = 1'b0, clr_rx_avail = 1'b0, clr_ovf = 1'b0;
    logic       irq_en = 1'b0;
    logic       tx_done, rx_avail, rx_ovf, irq;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    int tdiv = 0;
    localparam int BITCLK = 64;

    logic [7:0] mq [0:2];
    int mc = 0;
    logic [7:0] last_rd = 8'h00;

    serial_port_core u0 (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd), .txd(txd),
        .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en), .rdata(rdata),
        .clr_tx_done(clr_tx_done), .clr_rx_avail(clr_rx_avail), .clr_ovf(clr_ovf),
        .irq_en(irq_en), .tx_done(tx_done), .rx_avail(rx_avail), .rx_ovf(rx_ovf),
        .irq(irq)
    );

    always #4 clk = ~clk;

    always @(negedge clk) begin
        tdiv      <= (tdiv == 3) ? 0 : tdiv + 1;
        baud_tick <= (tdiv == 3);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_irq(input logic en, input logic td, input logic ra);
        return en & (td | ra);
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stop_bit);
        rxd = 1'b0;
        wait_clk(BITCLK);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            wait_clk(BITCLK);
        end
        rxd = stop_bit;
        wait_clk(BITCLK);
        rxd = 1'b1;
        wait_clk(8);
    endtask

    task automatic model_rx(input logic [7:0] b);
        if (mc < 3) begin
            mq[mc] = b;
            mc++;
        end
    endtask

    task automatic do_read;
        @(negedge clk) rd_en = 1'b1;
        @(negedge clk) rd_en = 1'b0;
    endtask

    task automatic read_check(input string req);
        logic [7:0] e;
        e = (mc > 0) ? mq[0] : last_rd;
        if (mc > 0) begin
            mq[0] = mq[1];
            mq[1] = mq[2];
            mc--;
        end
        do_read();
        chk(req, {24'h0, rdata}, {24'h0, e});
        last_rd = e;
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk) sig = 1'b1;
        @(negedge clk) sig = 1'b0;
    endtask

    task automatic tx_check(input logic [7:0] b);
        logic [7:0] got;
        int w;
        got = '0;
        @(negedge clk) begin wr_en = 1'b1; wdata = b; end
        @(negedge clk) wr_en = 1'b0;
        w = 0;
        while (txd === 1'b1 && w < 200) begin
            @(negedge clk);
            w++;
        end
        wait_clk(BITCLK / 2);
        chk("R2 start bit", {31'h0, txd}, 32'h0);
        for (int i = 0; i < 8; i++) begin
            wait_clk(BITCLK);
            got[i] = txd;
        end
        wait_clk(BITCLK);
        chk("R2 stop bit", {31'h0, txd}, 32'h1);
        chk("R2 data byte", {24'h0, got}, {24'h0, b});
        wait_clk(BITCLK / 2 + 8);
        chk("R3 tx_done set", {31'h0, tx_done}, 32'h1);
    endtask

    initial begin
        int unsigned seed;
        logic [7:0] b;
        seed = $urandom(32'd2024);
        wait_clk(5);
        // R1 reset state
        chk("R1 txd", {31'h0, txd}, 32'h1);
        chk("R1 tx_done", {31'h0, tx_done}, 32'h0);
        chk("R1 rx_avail", {31'h0, rx_avail}, 32'h0);
        chk("R1 rx_ovf", {31'h0, rx_ovf}, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 rdata", {24'h0, rdata}, 32'h0);
        rst_n = 1'b1;
        wait_clk(10);

        // R4 single byte, R9 interrupt gating
        send_rx(8'hA5, 1'b1); model_rx(8'hA5);
        chk("R4 rx_avail", {31'h0, rx_avail}, 32'h1);
        chk("R9 irq disabled", {31'h0, irq}, {31'h0, exp_irq(1'b0, 1'b0, 1'b1)});
        irq_en = 1'b1;
        wait_clk(1);
        chk("R9 irq enabled", {31'h0, irq}, {31'h0, exp_irq(1'b1, 1'b0, 1'b1)});
        read_check("R4 read byte");
        chk("R7 flag kept after read", {31'h0, rx_avail}, 32'h1);
        pulse(clr_rx_avail);
        chk("R7 clear when empty", {31'h0, rx_avail}, 32'h0);
        chk("R9 irq drops", {31'h0, irq}, 32'h0);

        // R5 fill, overflow, order; R7 refused clear; R6 sticky
        send_rx(8'h11, 1'b1); model_rx(8'h11);
        send_rx(8'h22, 1'b1); model_rx(8'h22);
        send_rx(8'h33, 1'b1); model_rx(8'h33);
        chk("R5 no overflow at three", {31'h0, rx_ovf}, 32'h0);
        send_rx(8'h44, 1'b1); model_rx(8'h44);
        chk("R5 overflow on fourth", {31'h0, rx_ovf}, 32'h1);
        pulse(clr_rx_avail);
        chk("R7 clear refused full", {31'h0, rx_avail}, 32'h1);
        read_check("R5 order first");
        read_check("R5 order second");
        pulse(clr_rx_avail);
        chk("R7 clear refused one left", {31'h0, rx_avail}, 32'h1);
        read_check("R5 order third, fourth lost");
        chk("R6 ovf survives reads", {31'h0, rx_ovf}, 32'h1);
        pulse(clr_ovf);
        chk("R6 ovf cleared", {31'h0, rx_ovf}, 32'h0);

        // R8 empty read
        read_check("R8 empty read keeps rdata");
        chk("R8 rx_avail unchanged", {31'h0, rx_avail}, 32'h1);
        pulse(clr_rx_avail);
        read_check("R8 second empty read");
        chk("R8 flags unchanged", {29'h0, rx_avail, rx_ovf, tx_done}, 32'h0);

        // R10 short glitch
        rxd = 1'b0; wait_clk(16); rxd = 1'b1;
        wait_clk(BITCLK * 11);
        chk("R10 glitch ignored", {31'h0, rx_avail}, 32'h0);
        read_check("R10 nothing queued");

        // R11 bad stop bit
        send_rx(8'h5A, 1'b0);
        wait_clk(BITCLK * 2);
        chk("R11 bad frame dropped", {31'h0, rx_avail}, 32'h0);
        read_check("R11 nothing queued");

        // R2 / R3 transmit
        irq_en = 1'b0;
        tx_check(8'hC3);
        chk("R9 irq off with tx_done", {31'h0, irq}, 32'h0);
        irq_en = 1'b1;
        wait_clk(1);
        chk("R9 irq on with tx_done", {31'h0, irq}, 32'h1);
        do_read();
        wait_clk(100);
        chk("R3 tx_done holds", {31'h0, tx_done}, 32'h1);
        pulse(clr_tx_done);
        chk("R3 tx_done cleared", {31'h0, tx_done}, 32'h0);
        tx_check(8'h01);
        pulse(clr_tx_done);
        chk("R2 txd idles high", {31'h0, txd}, 32'h1);

        // random phase: R4 R5 R7 with a queue model
        for (int k = 0; k < 24; k++) begin
            b = 8'($urandom);
            if (mc == 3) begin
                send_rx(b, 1'b1);
                chk("R5 random overflow", {31'h0, rx_ovf}, 32'h1);
                pulse(clr_ovf);
            end else begin
                send_rx(b, 1'b1);
                model_rx(b);
            end
            if ($urandom % 3 != 0) read_check("R4 random read");
            if (mc > 1) begin
                pulse(clr_rx_avail);
                chk("R7 random refuse", {31'h0, rx_avail}, 32'h1);
            end
        end
        while (mc > 0) read_check("R5 drain");
        pulse(clr_rx_avail);
        chk("R7 final clear", {31'h0, rx_avail}, 32'h0);
        for (int k = 0; k < 3; k++) begin
            tx_check(8'($urandom));
            pulse(clr_tx_done);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule